// File: doc/BRIEF.md
# Two-Channel Compare Timer with Automatic Compare Advance

This block holds a 10-bit up-counter that runs freely and wraps. Two compare channels watch it. Each channel has a compare register and an increment register. When the counter steps onto a channel's compare value, the channel raises a one-cycle event and latches a sticky flag. Those flags can raise a shared interrupt.

Each channel works in one of two modes. In reload mode a channel fires once and then goes idle until software writes a fresh compare value. In auto-advance mode the hardware adds the increment to the compare value after each event, modulo 1024, so the channel keeps firing at a fixed spacing with no processor action. This suits pulse-position and pulse-width schemes.

The counter does not advance on every clock. Its advance enable comes from one of three sources: the system clock divided by two, the system clock divided by sixteen, or a single-cycle tick from another timer. The source can also be switched off.

Top module: `stepcmp_timer`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `count` = 0, `evt` = 0, `flags` = 0 and `irq` = 0, and both channels are left idle (not armed) with compare and increment values of 0.
- R2: Each advance tick raises `count` by exactly one, and 1023 is followed by 0. Without a tick `count` holds its value.
- R3: `src_sel` picks the tick source. 0 ticks on every second clock, 1 ticks on every sixteenth clock, 2 ticks on each clock where `ext_tick` is high, and 3 gives no ticks at all, so the count is frozen.
- R4: An armed channel raises its `evt` bit for exactly one cycle: the first cycle in which `count` shows that channel's compare value after a tick. A compare value equal to the count already shown fires only after the counter comes back round to it.
- R5: In reload mode (`step_mode` bit = 0), a channel goes idle after an event. It gives no further event, even across a full wrap of the counter, until its compare register is written again.
- R6: In auto-advance mode (`step_mode` bit = 1), each event replaces the compare value with compare + increment modulo 1024, and the channel stays armed.
- R7: A write with `wr_step` = 0 loads `wr_data` into the compare register of channel `wr_ch` and arms that channel. If the write lands in the same cycle as an event, the event still fires and the written value and armed state take effect.
- R8: `flags` bit i is set by every event on channel i and holds until a cycle with `stat_rd` high clears it. An event in the same cycle as `stat_rd` leaves the flag set.
- R9: `irq` is high exactly when some channel has both its flag and its `irq_en` bit set.
- R10: A write with `wr_step` = 1 loads only the increment register of channel `wr_ch`. It neither arms the channel nor changes its compare value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| src_sel | input | 2 | Tick source: 0 clk/2, 1 clk/16, 2 ext_tick, 3 off |
| ext_tick | input | 1 | Single-cycle tick from another timer |
| step_mode | input | 2 | Per channel: 1 auto-advance, 0 reload mode |
| irq_en | input | 2 | Per-channel interrupt enable |
| wr_en | input | 1 | Register write strobe |
| wr_ch | input | 1 | Channel addressed by the write |
| wr_step | input | 1 | 1 writes the increment register, 0 writes the compare register |
| wr_data | input | 10 | Write value |
| stat_rd | input | 1 | Status read strobe, clears all flags |
| count | output | 10 | Current counter value |
| evt | output | 2 | Per-channel one-cycle event |
| flags | output | 2 | Per-channel sticky event flags |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that reset is held for at least two clock edges, so that every `$past` value they use comes from a defined counter. They also assume that `src_sel` is a registered control that is stable around each edge. The bench holds reset for three cycles. It changes `src_sel`, the write strobes and `stat_rd` only on falling edges. It stops the counter with source 3 before writing a compare value, except in the deliberate same-cycle collision case, where the timing is worked out edge by edge.

// File: rtl/stepcmp_pkg.sv
`timescale 1ns/1ps
package stepcmp_pkg;
    localparam int CNT_W    = 10;
    localparam int CH_N     = 2;
    localparam int CH_IDX_W = (CH_N > 1) ? $clog2(CH_N) : 1;

    typedef logic [CNT_W-1:0] cnt_t;

    typedef enum logic [1:0] {
        SRC_HALF = 2'd0,
        SRC_SLOW = 2'd1,
        SRC_EXT  = 2'd2,
        SRC_OFF  = 2'd3
    } src_e;

    typedef struct packed {
        logic armed;
        cnt_t cmp;
        cnt_t inc;
    } chan_t;

    typedef struct packed {
        logic ld_cmp;
        logic ld_inc;
        cnt_t data;
    } chan_wr_t;

    function automatic cnt_t advance_point(cnt_t cur, cnt_t inc);
        return cur + inc;
    endfunction
endpackage

// File: rtl/stepcmp_tick.sv
`timescale 1ns/1ps
module stepcmp_tick
    import stepcmp_pkg::*;
#(
    parameter int SLOW_DIV = 16
) (
    input  logic clk,
    input  logic rst,
    input  src_e src,
    input  logic ext_tick,
    output logic tick
);
    localparam int PW = $clog2(SLOW_DIV);

    logic [PW-1:0] pre;

    always_ff @(posedge clk) begin
        if (rst) pre <= '0;
        else     pre <= pre + PW'(1);
    end

    always_comb begin
        unique case (src)
            SRC_HALF: tick = pre[0];
            SRC_SLOW: tick = &pre;
            SRC_EXT:  tick = ext_tick;
            default:  tick = 1'b0;
        endcase
    end
endmodule

// File: rtl/stepcmp_chan.sv
`timescale 1ns/1ps
module stepcmp_chan
    import stepcmp_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     tick,
    input  cnt_t     cnt,
    input  logic     auto_adv,
    input  chan_wr_t wr,
    input  logic     clr,
    output logic     evt,
    output logic     flag
);
    chan_t st;
    cnt_t  cnt_nx;
    logic  hit;

    assign cnt_nx = cnt + cnt_t'(1);
    assign hit    = tick && st.armed && (cnt_nx == st.cmp);

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= '0;
            evt  <= 1'b0;
            flag <= 1'b0;
        end else begin
            evt <= hit;
            if (hit) begin
                if (auto_adv) st.cmp   <= advance_point(st.cmp, st.inc);
                else          st.armed <= 1'b0;
            end
            if (wr.ld_inc) st.inc <= wr.data;
            if (wr.ld_cmp) begin
                st.cmp   <= wr.data;
                st.armed <= 1'b1;
            end
            if (hit)      flag <= 1'b1;
            else if (clr) flag <= 1'b0;
        end
    end
endmodule

// File: rtl/stepcmp_timer.sv
`timescale 1ns/1ps
module stepcmp_timer
    import stepcmp_pkg::*;
#(
    parameter int SLOW_DIV = 16
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [1:0]          src_sel,
    input  logic                ext_tick,
    input  logic [CH_N-1:0]     step_mode,
    input  logic [CH_N-1:0]     irq_en,
    input  logic                wr_en,
    input  logic [CH_IDX_W-1:0] wr_ch,
    input  logic                wr_step,
    input  logic [CNT_W-1:0]    wr_data,
    input  logic                stat_rd,
    output logic [CNT_W-1:0]    count,
    output logic [CH_N-1:0]     evt,
    output logic [CH_N-1:0]     flags,
    output logic                irq
);
    src_e src;
    logic tick;
    cnt_t cnt_q;

    assign src = src_e'(src_sel);

    stepcmp_tick #(.SLOW_DIV(SLOW_DIV)) u_tick (
        .clk      (clk),
        .rst      (rst),
        .src      (src),
        .ext_tick (ext_tick),
        .tick     (tick)
    );

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (tick) cnt_q <= cnt_q + cnt_t'(1);
    end

    for (genvar i = 0; i < CH_N; i++) begin : g_chan
        chan_wr_t w;
        logic     sel;
        assign sel      = wr_en && (wr_ch == CH_IDX_W'(i));
        assign w.ld_cmp = sel && !wr_step;
        assign w.ld_inc = sel && wr_step;
        assign w.data   = wr_data;

        stepcmp_chan u_chan (
            .clk      (clk),
            .rst      (rst),
            .tick     (tick),
            .cnt      (cnt_q),
            .auto_adv (step_mode[i]),
            .wr       (w),
            .clr      (stat_rd),
            .evt      (evt[i]),
            .flag     (flags[i])
        );
    end

    assign count = cnt_q;
    assign irq   = |(flags & irq_en);
endmodule

// File: rtl/stepcmp_chk.sv
`timescale 1ns/1ps
module stepcmp_chk
    import stepcmp_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic [1:0]       src_sel,
    input logic [CNT_W-1:0] count,
    input logic [CH_N-1:0]  evt,
    input logic [CH_N-1:0]  flags,
    input logic             stat_rd
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (count == '0 && evt == '0 && flags == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (count == $past(count) || count == cnt_t'($past(count) + 1'b1)));

    // R3
    src_off_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (src_sel == SRC_OFF) |=> $stable(count));

    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        // R8
        flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !stat_rd) |=> flags[i]);

        // R4
        evt_flag_chk: assert property (@(posedge clk) disable iff (rst)
            evt[i] |-> flags[i]);
    end
endmodule

bind stepcmp_timer stepcmp_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .src_sel (src_sel),
    .count   (count),
    .evt     (evt),
    .flags   (flags),
    .stat_rd (stat_rd)
);

// File: tb/tb_stepcmp_timer.sv
`timescale 1ns/1ps
module tb_stepcmp_timer;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] src_sel = 2'd3;
    logic       ext_tick = 1'b0;
    logic [1:0] step_mode = 2'b00;
    logic [1:0] irq_en = 2'b00;
    logic       wr_en = 1'b0;
    logic [0:0] wr_ch = 1'b0;
    logic       wr_step = 1'b0;
    logic [9:0] wr_data = '0;
    logic       stat_rd = 1'b0;
    logic [9:0] count;
    logic [1:0] evt;
    logic [1:0] flags;
    logic       irq;

    typedef struct { int ch; int val; } exp_t;
    exp_t sb[$];
    int   nchk = 0;
    int   nerr = 0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    stepcmp_timer dut (
        .clk(clk), .rst(rst), .src_sel(src_sel), .ext_tick(ext_tick),
        .step_mode(step_mode), .irq_en(irq_en), .wr_en(wr_en), .wr_ch(wr_ch),
        .wr_step(wr_step), .wr_data(wr_data), .stat_rd(stat_rd),
        .count(count), .evt(evt), .flags(flags), .irq(irq)
    );

    function automatic int m(int v);
        return v & 1023;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
        end
    endtask

    task automatic push(int ch, int val);
        exp_t e;
        e.ch = ch;
        e.val = m(val);
        sb.push_back(e);
    endtask

    // monitor: pops expected events as the design raises them (R4)
    always @(negedge clk) begin
        if (!rst) begin
            for (int i = 0; i < 2; i++) begin
                if (evt[i]) begin
                    if (sb.size() == 0) begin
                        chk(1'b0, "R4/R5 unexpected event", i, -1);
                    end else begin
                        exp_t e;
                        e = sb.pop_front();
                        chk(e.ch == i, "R4 event channel", i, e.ch);
                        chk(int'(count) == e.val, "R4 count at event", count, e.val);
                    end
                end
            end
        end
    end

    task automatic wr(int ch, bit stp, int val);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = ch[0]; wr_step = stp; wr_data = val[9:0];
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic run(int n);
        src_sel = 2'd2; ext_tick = 1'b1;
        repeat (n) @(posedge clk);
        @(negedge clk);
        src_sel = 2'd3; ext_tick = 1'b0;
    endtask

    task automatic clear_flags();
        @(negedge clk); stat_rd = 1'b1;
        @(negedge clk); stat_rd = 1'b0;
    endtask

    initial begin
        int c;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk(count == 0, "R1 count", count, 0);
        chk(evt == 0, "R1 evt", evt, 0);
        chk(flags == 0, "R1 flags", flags, 0);
        chk(irq == 0, "R1 irq", irq, 0);

        // R3 source off holds
        repeat (5) @(negedge clk);
        chk(count == 0, "R3 off", count, 0);

        // R3 clk/2
        c = count; src_sel = 2'd0;
        repeat (32) @(negedge clk);
        src_sel = 2'd3;
        chk(int'(count) == m(c + 16), "R3 half", count, m(c + 16));

        // R3 clk/16
        c = count; src_sel = 2'd1;
        repeat (64) @(negedge clk);
        src_sel = 2'd3;
        chk(int'(count) == m(c + 4), "R3 slow", count, m(c + 4));

        // R3 external ticks, sparse pattern
        c = count; src_sel = 2'd2;
        for (int i = 0; i < 10; i++) begin
            ext_tick = (i % 3 == 0);
            @(negedge clk);
        end
        src_sel = 2'd3; ext_tick = 1'b0;
        chk(int'(count) == m(c + 4), "R3 ext", count, m(c + 4));

        // R2 wrap
        c = count;
        run(1023 - c);
        chk(count == 1023, "R2 top", count, 1023);
        run(1);
        chk(count == 0, "R2 wrap", count, 0);

        // R10 increment write does not arm
        wr(0, 1'b1, 7);
        run(1100);
        chk(flags == 0, "R10 no arm", flags, 0);

        // R4/R5 reload mode
        c = count;
        wr(0, 1'b0, m(c + 5));
        push(0, c + 5);
        run(12);
        chk(sb.size() == 0, "R4 event seen", sb.size(), 0);
        chk(flags[0] == 1'b1, "R8 flag set", flags[0], 1);
        chk(irq == 1'b0, "R9 irq masked", irq, 0);
        irq_en = 2'b01;
        @(negedge clk);
        chk(irq == 1'b1, "R9 irq enabled", irq, 1);
        run(1100);
        chk(flags[0] == 1'b1, "R8 sticky", flags[0], 1);
        clear_flags();
        chk(flags == 0, "R8 cleared", flags, 0);
        chk(irq == 1'b0, "R9 irq low", irq, 0);
        irq_en = 2'b00;

        // R6 auto-advance with modular wrap
        c = count;
        step_mode = 2'b10;
        wr(1, 1'b1, 400);
        wr(1, 1'b0, m(c + 10));
        push(1, c + 10); push(1, c + 410); push(1, c + 810); push(1, c + 1210);
        run(1250);
        chk(sb.size() == 0, "R6 advancing events", sb.size(), 0);
        step_mode = 2'b00;
        push(1, c + 1610);
        run(400);
        chk(sb.size() == 0, "R6 next point", sb.size(), 0);
        clear_flags();

        // R7/R8 write and read in the event cycle
        c = count;
        wr(0, 1'b0, m(c + 3));
        push(0, c + 3); push(0, c + 8);
        src_sel = 2'd2; ext_tick = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        wr_en = 1'b1; wr_ch = 1'b0; wr_step = 1'b0; wr_data = m(c + 8)[9:0]; stat_rd = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; stat_rd = 1'b0;
        chk(int'(count) == m(c + 3), "R7 event cycle", count, m(c + 3));
        chk(flags[0] == 1'b1, "R8 set beats clear", flags[0], 1);
        repeat (10) @(negedge clk);
        src_sel = 2'd3; ext_tick = 1'b0;
        chk(sb.size() == 0, "R7 rearmed event", sb.size(), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nchk++; nerr++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule